// File: doc/BRIEF.md
# SPI Header-Phase Transfer Sequencer

This block runs one flash-style serial transaction as a chain of phases: an instruction, an address, a read-mode byte group, a dummy gap and then the payload. A 16-bit header-count word gives the byte count of each header phase. The block drives the chip select, the serial clock and four bidirectional data lanes. An external divider supplies a half-period tick, and simple valid/ready ports connect it to an outbound word FIFO and an inbound word FIFO.

A write moves words out of the outbound FIFO until a stop request is seen while that FIFO is empty. A read collects a programmed number of bytes and then ends by itself. The payload can use one, two or four lanes. The instruction always uses one lane, and the address and read-mode phases use one lane unless the wide-header bit is set. All configuration is captured when a transfer starts. The serial clock idles low, outputs change after falling edges and inputs are sampled on rising edges.

Top module: `spi_phase_seq`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, busy and done are 0, io_oe is 0, rd_valid is 0 and wr_ready is 0.
- R2: The header-count word holds the instruction byte count in bits [1:0], the address byte count in bits [6:4], the read-mode byte count in bits [9:8] and the dummy byte count in bits [14:12]. Phases run in the order instruction, address, read-mode, dummy, payload, and a phase whose count is 0 produces no clock edges.
- R3: For a header phase of n bytes, the bytes sent are bytes n-1 down to 0 of that phase's 32-bit value (byte k is bits 8k+7..8k). A byte index of 4 or more sends 0x00. Every byte is sent most significant bit first.
- R4: Lane width code: lane_quad=1 selects four lanes (io3..io0 carry bits 7..4 first), otherwise lane_dual=1 selects two lanes (io1 then io0 carry bits 7,6 first), otherwise one lane is used (output on io0, input on io1). io_oe is 0001, 0011 or 1111 accordingly. The instruction always uses one lane. Address and read-mode use the payload width only when addr_wide=1. Dummy bytes use the payload width with io_oe=0000.
- R5: In a read (dir_wr=0 at start), the payload runs for din_cnt bytes with io_oe=0000 and then the transfer ends. With word_mode=1, received bytes are packed with the first byte in bits [7:0], and a word is pushed after 4 bytes or after the final byte (unused upper bytes are 0). With word_mode=0, each byte is pushed alone in bits [7:0].
- R6: In a write (dir_wr=1 at start), each outbound word is sent from bits [7:0] upward, one byte at a time, when word_mode=1, or as bits [7:0] only when word_mode=0. A word still in the FIFO is always sent before the transfer ends. The transfer ends only when stop_req=1 and the FIFO is empty at a byte boundary, and until then it waits with sclk low.
- R7: Direction, lane choice, word mode, counts and header values are captured when start is seen while idle. A start pulse or a change of dir_wr during a transfer has no effect.
- R8: cs_n is 0 at every rising sclk edge of a transfer. It falls at least one tick period before the first rising edge and returns to 1 after the last falling edge.
- R9: done is a single-cycle pulse in the cycle after busy drops, exactly once per transfer.
- R10: While rd_valid is 1 and rd_ready is 0, rd_valid and rd_data hold their values and sclk makes no edge.
- R11: sclk is low when idle and changes only on sclk_tick cycles. Each rising edge has a matching falling edge within the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_tick | input | 1 | Half-period enable from the external clock divider |
| start | input | 1 | Begin a transfer (taken only when idle) |
| stop_req | input | 1 | Allow a write to end once the outbound FIFO is empty |
| dir_wr | input | 1 | 1 selects write, 0 selects read |
| lane_dual | input | 1 | Two-lane payload |
| lane_quad | input | 1 | Four-lane payload (takes priority over two-lane) |
| addr_wide | input | 1 | Address and read-mode phases use the payload width |
| word_mode | input | 1 | 1 selects 32-bit words, 0 selects single bytes |
| hdr_cnt | input | 16 | Per-phase header byte counts |
| instr_val | input | 32 | Instruction bytes |
| addr_val | input | 32 | Address bytes |
| rmode_val | input | 32 | Read-mode bytes |
| din_cnt | input | CNT_W | Read payload length in bytes |
| wr_data | input | 32 | Outbound FIFO word |
| wr_valid | input | 1 | Outbound FIFO holds a word |
| wr_ready | output | 1 | Outbound word taken this cycle |
| rd_data | output | 32 | Inbound word |
| rd_valid | output | 1 | Inbound word available |
| rd_ready | input | 1 | Inbound FIFO accepts the word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
Header-only writes with uneven phase counts show that zero-count phases are skipped and that header bytes go out in the right order. An address count of five exposes the zero byte sent for an out-of-range index. A four-lane read with a wide header, read-mode and dummy bytes separates the lane mapping of each phase and shows the released lanes, and a two-lane write with a narrow header confirms that the header stays on one lane. Byte-mode and word-mode runs in each direction tell the packing rules apart. A stalled inbound FIFO, a write that waits on an empty FIFO without a stop request, and a second start pulse with a changed direction during a transfer check backpressure, write termination and the capture of configuration at start.

// File: rtl/spi_phase_seq.sv
module spi_phase_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_tick,
  input  logic             start,
  input  logic             stop_req,
  input  logic             dir_wr,
  input  logic             lane_dual,
  input  logic             lane_quad,
  input  logic             addr_wide,
  input  logic             word_mode,
  input  logic [15:0]      hdr_cnt,
  input  logic [31:0]      instr_val,
  input  logic [31:0]      addr_val,
  input  logic [31:0]      rmode_val,
  input  logic [CNT_W-1:0] din_cnt,
  input  logic [31:0]      wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [31:0]      rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             busy,
  output logic             done,
  output logic             cs_n,
  output logic             sclk,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  input  logic [3:0]       io_in
);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOAD, S_LOW, S_HIGH} st_t;
  typedef enum logic [2:0] {P_INS, P_ADR, P_RMD, P_DMY, P_DAT} ph_t;

  st_t st;
  ph_t ph;
  logic             busy_q, done_q, cs_q, sclk_q;
  logic             c_wr, c_awide, c_word;
  logic [1:0]       c_w;
  logic [15:0]      c_hdr;
  logic [31:0]      c_ins, c_adr, c_rmd;
  logic [CNT_W-1:0] c_din, left, nxt_cnt, hidx;
  logic [7:0]       sh, rx, hbyte, sh_next, rx_next;
  logic [3:0]       slot, spb;
  logic [31:0]      wword, rword, rword_n, rdd, hval;
  logic [1:0]       wleft, ridx, wcode;
  logic             rdv;

  assign wcode = (ph == P_INS) ? 2'd0 :
                 ((ph == P_ADR || ph == P_RMD) && !c_awide) ? 2'd0 : c_w;
  assign spb   = 4'd8 >> wcode;
  assign hval  = (ph == P_INS) ? c_ins : (ph == P_ADR) ? c_adr : c_rmd;
  assign hidx  = left - 1'b1;
  assign hbyte = (hidx < CNT_W'(4)) ? hval[{hidx[1:0], 3'b000} +: 8] : 8'h00;

  always_comb begin
    case (ph)
      P_INS:   nxt_cnt = CNT_W'(c_hdr[6:4]);
      P_ADR:   nxt_cnt = CNT_W'(c_hdr[9:8]);
      P_RMD:   nxt_cnt = CNT_W'(c_hdr[14:12]);
      default: nxt_cnt = c_wr ? '0 : c_din;
    endcase
  end

  always_comb begin
    case (wcode)
      2'd0:    begin sh_next = {sh[6:0], 1'b0}; rx_next = {rx[6:0], io_in[1]};   end
      2'd1:    begin sh_next = {sh[5:0], 2'b0}; rx_next = {rx[5:0], io_in[1:0]}; end
      default: begin sh_next = {sh[3:0], 4'b0}; rx_next = {rx[3:0], io_in};      end
    endcase
  end

  assign rword_n = rword | ({24'h0, rx} << {ridx, 3'b000});

  assign wr_ready = (st == S_LOAD) && !rdv && (ph == P_DAT) && c_wr && (wleft == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;   ph <= P_INS;
      busy_q <= 1'b0; done_q <= 1'b0; cs_q <= 1'b0; sclk_q <= 1'b0;
      c_wr <= 1'b0;   c_awide <= 1'b0; c_word <= 1'b0; c_w <= 2'd0;
      c_hdr <= '0;    c_ins <= '0; c_adr <= '0; c_rmd <= '0; c_din <= '0;
      left <= '0;     sh <= '0; rx <= '0; slot <= '0;
      wword <= '0;    wleft <= '0; rword <= '0; ridx <= '0;
      rdd <= '0;      rdv <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (rdv && rd_ready) rdv <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          c_wr    <= dir_wr;
          c_awide <= addr_wide;
          c_word  <= word_mode;
          c_w     <= lane_quad ? 2'd2 : lane_dual ? 2'd1 : 2'd0;
          c_hdr   <= hdr_cnt;
          c_ins   <= instr_val;
          c_adr   <= addr_val;
          c_rmd   <= rmode_val;
          c_din   <= din_cnt;
          ph      <= P_INS;
          left    <= CNT_W'(hdr_cnt[1:0]);
          wleft   <= 2'd0;
          ridx    <= 2'd0;
          rword   <= '0;
          busy_q  <= 1'b1;
          cs_q    <= 1'b1;
          st      <= S_SETUP;
        end
        S_SETUP: if (sclk_tick) st <= S_LOAD;
        S_LOAD: if (!rdv) begin
          if (ph != P_DAT) begin
            if (left == '0) begin
              ph   <= ph_t'(ph + 3'd1);
              left <= nxt_cnt;
            end else begin
              sh   <= (ph == P_DMY) ? 8'h00 : hbyte;
              left <= left - 1'b1;
              slot <= spb;
              st   <= S_LOW;
            end
          end else if (!c_wr) begin
            if (left == '0) begin
              st <= S_IDLE; busy_q <= 1'b0; cs_q <= 1'b0; done_q <= 1'b1;
            end else begin
              sh   <= 8'h00;
              left <= left - 1'b1;
              slot <= spb;
              st   <= S_LOW;
            end
          end else if (wleft != 2'd0) begin
            sh    <= wword[7:0];
            wword <= {8'h00, wword[31:8]};
            wleft <= wleft - 1'b1;
            slot  <= spb;
            st    <= S_LOW;
          end else if (wr_valid) begin
            sh    <= wr_data[7:0];
            wword <= {8'h00, wr_data[31:8]};
            wleft <= c_word ? 2'd3 : 2'd0;
            slot  <= spb;
            st    <= S_LOW;
          end else if (stop_req) begin
            st <= S_IDLE; busy_q <= 1'b0; cs_q <= 1'b0; done_q <= 1'b1;
          end
        end
        S_LOW: if (sclk_tick) begin
          sclk_q <= 1'b1;
          rx     <= rx_next;
          st     <= S_HIGH;
        end
        S_HIGH: if (sclk_tick) begin
          sclk_q <= 1'b0;
          sh     <= sh_next;
          slot   <= slot - 1'b1;
          if (slot == 4'd1) begin
            st <= S_LOAD;
            if (ph == P_DAT && !c_wr) begin
              if (!c_word || ridx == 2'd3 || left == '0) begin
                rdd   <= rword_n;
                rdv   <= 1'b1;
                rword <= '0;
                ridx  <= 2'd0;
              end else begin
                rword <= rword_n;
                ridx  <= ridx + 1'b1;
              end
            end
          end else begin
            st <= S_LOW;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic drive;
  assign drive = (st == S_LOW || st == S_HIGH) &&
                 (ph == P_INS || ph == P_ADR || ph == P_RMD || (ph == P_DAT && c_wr));

  always_comb begin
    case (wcode)
      2'd0:    begin io_out = {3'b000, sh[7]};   io_oe = drive ? 4'b0001 : 4'b0000; end
      2'd1:    begin io_out = {2'b00, sh[7:6]};  io_oe = drive ? 4'b0011 : 4'b0000; end
      default: begin io_out = sh[7:4];           io_oe = drive ? 4'b1111 : 4'b0000; end
    endcase
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign cs_n     = ~cs_q;
  assign sclk     = sclk_q;
  assign rd_data  = rdd;
  assign rd_valid = rdv;

  assert_idle_lines_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sclk && io_oe == 4'b0000));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_rd_no_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> $stable(sclk));

  assert_sclk_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_tick |=> $stable(sclk));

  assert_wr_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (busy && !sclk && !cs_n));

endmodule

// File: tb/tb_spi_phase_seq.sv
module tb_spi_phase_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int CNT_W      = 16;
  localparam int DEPTH      = 1024;

  logic clk = 0, rst_n = 0, sclk_tick;
  logic start = 0, stop_req = 0, dir_wr = 0, lane_dual = 0, lane_quad = 0;
  logic addr_wide = 0, word_mode = 0, rd_ready = 1;
  logic [15:0] hdr_cnt = 0;
  logic [31:0] instr_val = 0, addr_val = 0, rmode_val = 0;
  logic [CNT_W-1:0] din_cnt = 0;
  logic [31:0] wr_data, rd_data;
  logic wr_valid, wr_ready, rd_valid, busy, done, cs_n, sclk;
  logic [3:0] io_out, io_oe, io_in;

  spi_phase_seq #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .sclk_tick(sclk_tick), .start(start), .stop_req(stop_req),
    .dir_wr(dir_wr), .lane_dual(lane_dual), .lane_quad(lane_quad), .addr_wide(addr_wide),
    .word_mode(word_mode), .hdr_cnt(hdr_cnt), .instr_val(instr_val), .addr_val(addr_val),
    .rmode_val(rmode_val), .din_cnt(din_cnt), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .busy(busy), .done(done), .cs_n(cs_n), .sclk(sclk), .io_out(io_out), .io_oe(io_oe),
    .io_in(io_in));

  always #(CLK_PERIOD/2) clk = ~clk;

  int tdiv = 0;
  always @(posedge clk) tdiv <= (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
  assign sclk_tick = (tdiv == TICK_DIV-1);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [3:0] exp_out [DEPTH], exp_oe [DEPTH], stream [DEPTH], ev_out [DEPTH], ev_oe [DEPTH];
  bit exp_drv [DEPTH];
  int en = 0, ecnt = 0, cs_bad = 0;

  assign io_in = (ecnt < DEPTH) ? stream[ecnt] : 4'h0;

  always @(posedge sclk) begin
    if (ecnt < DEPTH) begin
      ev_out[ecnt] <= io_out;
      ev_oe[ecnt]  <= io_oe;
    end
    if (cs_n) cs_bad <= cs_bad + 1;
    ecnt <= ecnt + 1;
  end

  logic [31:0] wq [64];
  int wq_n = 0, wq_i = 0;
  assign wr_valid = (wq_i < wq_n);
  assign wr_data  = wq[wq_i % 64];
  always @(posedge clk) if (wr_valid && wr_ready) wq_i <= wq_i + 1;

  logic [31:0] rq [64];
  int rq_n = 0, dn = 0;
  always @(posedge clk) begin
    if (rd_valid && rd_ready) begin rq[rq_n % 64] <= rd_data; rq_n <= rq_n + 1; end
    if (done) dn <= dn + 1;
  end

  int cyc = 0, t_cs = 0, gap = 0;
  bit cs_prev = 1, sclk_prev = 0, armed = 0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (cs_prev && !cs_n) begin t_cs <= cyc; armed <= 1; end
    else if (armed && !sclk_prev && sclk) begin gap <= cyc - t_cs; armed <= 0; end
    cs_prev   <= cs_n;
    sclk_prev <= sclk;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic eb(input logic [7:0] b, input int w, input bit drv);
    logic [7:0] t;
    t = b;
    for (int s = 0; s < 8 / w; s++) begin
      logic [3:0] v;
      v = (w == 1) ? {3'b000, t[7]} : (w == 2) ? {2'b00, t[7:6]} : t[7:4];
      exp_out[en] = v;
      exp_drv[en] = drv;
      exp_oe[en]  = drv ? ((w == 1) ? 4'b0001 : (w == 2) ? 4'b0011 : 4'b1111) : 4'b0000;
      stream[en]  = drv ? 4'h0 : ((w == 1) ? {2'b00, t[7], 1'b0} : v);
      t = t << w;
      en++;
    end
  endtask

  task automatic push_w(input logic [31:0] w);
    wq[wq_n % 64] = w;
    wq_n++;
  endtask

  task automatic go();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic wait_done(input int dn0);
    int k;
    k = 0;
    while (dn == dn0 && k < 20000) begin @(negedge clk); k++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_xfer(input int base, input int dn0, input string req);
    int bad;
    bad = 0;
    for (int i = base; i < en; i++)
      if (ev_oe[i] !== exp_oe[i] || (exp_drv[i] && ev_out[i] !== exp_out[i])) bad++;
    chk(bad == 0, req, "lane values at rising edges (mismatches)", bad, 0);
    chk(ecnt == en, req, "rising edge count", ecnt - base, en - base);
    chk(dn == dn0 + 1, "R9", "done pulses", dn - dn0, 1);
    chk(cs_n && !sclk && !busy, "R8", "lines released after transfer", {cs_n, sclk, busy}, 3'b100);
    chk(cs_bad == 0, "R8", "rising edges with cs_n high", cs_bad, 0);
    chk(gap >= TICK_DIV, "R8", "cycles from cs_n fall to first rise", gap, TICK_DIV);
  endtask

  task automatic t_reset();
    chk(cs_n && !sclk && !busy && !done && io_oe == 0 && !rd_valid && !wr_ready,
        "R1", "reset state", {cs_n, sclk, busy, done, io_oe, rd_valid, wr_ready}, 10'b1000000000);
  endtask

  task automatic t_hdr_write();
    int base, dn0;
    base = ecnt; en = ecnt; dn0 = dn;
    dir_wr = 1; stop_req = 1; lane_dual = 0; lane_quad = 0; addr_wide = 0; word_mode = 1;
    hdr_cnt = 16'h0031; instr_val = 32'h0000009F; addr_val = 32'hAABBCCDD;
    eb(8'h9F, 1, 1); eb(8'hBB, 1, 1); eb(8'hCC, 1, 1); eb(8'hDD, 1, 1);
    go(); wait_done(dn0);
    chk_xfer(base, dn0, "R2 R3");
  endtask

  task automatic t_quad_read();
    int base, dn0, r0;
    base = ecnt; en = ecnt; dn0 = dn; r0 = rq_n;
    dir_wr = 0; lane_quad = 1; lane_dual = 0; addr_wide = 1; word_mode = 1; rd_ready = 1;
    hdr_cnt = 16'h2131; instr_val = 32'h000000EB; addr_val = 32'h00123456;
    rmode_val = 32'h000000A5; din_cnt = 6;
    eb(8'hEB, 1, 1); eb(8'h12, 4, 1); eb(8'h34, 4, 1); eb(8'h56, 4, 1);
    eb(8'hA5, 4, 1); eb(8'h00, 4, 0); eb(8'h00, 4, 0);
    for (int i = 1; i <= 6; i++) eb(8'(i * 8'h11), 4, 0);
    go(); wait_done(dn0);
    chk_xfer(base, dn0, "R4 R5 R11");
    chk(rq_n - r0 == 2, "R5", "quad read word count", rq_n - r0, 2);
    chk(rq[r0 % 64] == 32'h44332211, "R5", "quad read word 0", rq[r0 % 64], 32'h44332211);
    chk(rq[(r0 + 1) % 64] == 32'h00006655, "R5", "quad read partial word", rq[(r0 + 1) % 64], 32'h00006655);
    lane_quad = 0; addr_wide = 0;
  endtask

  task automatic t_dual_write();
    int base, dn0, w0;
    base = ecnt; en = ecnt; dn0 = dn; w0 = wq_i;
    dir_wr = 1; stop_req = 1; lane_dual = 1; addr_wide = 0; word_mode = 1;
    hdr_cnt = 16'h0021; instr_val = 32'h0000003B; addr_val = 32'h0000BEEF;
    push_w(32'h44332211); push_w(32'h88776655);
    eb(8'h3B, 1, 1); eb(8'hBE, 1, 1); eb(8'hEF, 1, 1);
    for (int i = 1; i <= 8; i++) eb(8'(i * 8'h11), 2, 1);
    go();
    repeat (20) @(negedge clk);
    dir_wr = 0;
    go();
    wait_done(dn0);
    chk_xfer(base, dn0, "R4 R6 R7");
    chk(wq_i - w0 == 2, "R7", "words taken after second start", wq_i - w0, 2);
    lane_dual = 0;
  endtask

  task automatic t_byte_write();
    int base, dn0;
    base = ecnt; en = ecnt; dn0 = dn;
    dir_wr = 1; stop_req = 1; word_mode = 0; hdr_cnt = 16'h0000;
    push_w(32'hDEADBEEF); push_w(32'h12345678);
    eb(8'hEF, 1, 1); eb(8'h78, 1, 1);
    go(); wait_done(dn0);
    chk_xfer(base, dn0, "R6");
  endtask

  task automatic t_byte_read();
    int base, dn0, r0;
    base = ecnt; en = ecnt; dn0 = dn; r0 = rq_n;
    dir_wr = 0; word_mode = 0; rd_ready = 1; hdr_cnt = 16'h0050;
    addr_val = 32'h01020304; din_cnt = 3;
    eb(8'h00, 1, 1); eb(8'h01, 1, 1); eb(8'h02, 1, 1); eb(8'h03, 1, 1); eb(8'h04, 1, 1);
    eb(8'hC3, 1, 0); eb(8'h5A, 1, 0); eb(8'h0F, 1, 0);
    go(); wait_done(dn0);
    chk_xfer(base, dn0, "R3 R5");
    chk(rq_n - r0 == 3, "R5", "byte read push count", rq_n - r0, 3);
    chk(rq[r0 % 64] == 32'hC3 && rq[(r0 + 1) % 64] == 32'h5A && rq[(r0 + 2) % 64] == 32'h0F,
        "R5", "byte read values", rq[(r0 + 1) % 64], 32'h5A);
  endtask

  task automatic t_backpressure();
    int base, dn0, r0, e_hold, k;
    base = ecnt; en = ecnt; dn0 = dn; r0 = rq_n;
    dir_wr = 0; word_mode = 1; rd_ready = 0; hdr_cnt = 16'h0000; din_cnt = 8;
    for (int i = 0; i < 8; i++) eb(8'(8'h10 + i), 1, 0);
    go();
    k = 0;
    while (!rd_valid && k < 5000) begin @(negedge clk); k++; end
    e_hold = ecnt;
    repeat (50) @(negedge clk);
    chk(ecnt == e_hold, "R10", "sclk rising edges during stall", ecnt - e_hold, 0);
    chk(rd_valid && rd_data == 32'h13121110, "R10", "held inbound word", rd_data, 32'h13121110);
    rd_ready = 1;
    wait_done(dn0);
    chk_xfer(base, dn0, "R10");
    chk(rq[(r0 + 1) % 64] == 32'h17161514, "R10", "second word after release", rq[(r0 + 1) % 64], 32'h17161514);
  endtask

  task automatic t_stop_wait();
    int base, dn0;
    base = ecnt; en = ecnt; dn0 = dn;
    dir_wr = 1; stop_req = 0; word_mode = 1; hdr_cnt = 16'h0000;
    push_w(32'hA1B2C3D4);
    eb(8'hD4, 1, 1); eb(8'hC3, 1, 1); eb(8'hB2, 1, 1); eb(8'hA1, 1, 1);
    go();
    repeat (400) @(negedge clk);
    chk(busy && !cs_n, "R6", "still active with empty FIFO and no stop", {busy, cs_n}, 2'b10);
    chk(ecnt == base + 32, "R6", "edges while waiting", ecnt - base, 32);
    eb(8'h0C, 1, 1); eb(8'h0D, 1, 1); eb(8'h0E, 1, 1); eb(8'h0F, 1, 1);
    push_w(32'h0F0E0D0C);
    stop_req = 1;
    wait_done(dn0);
    chk_xfer(base, dn0, "R6");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_hdr_write();
    t_quad_read();
    t_dual_write();
    t_byte_write();
    t_byte_read();
    t_backpressure();
    t_stop_wait();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule